// File: doc/BRIEF.md
# PRBS Link Self-Test Checker

This block sits on the receive side of a serial video link and checks the link with a pseudo-random test pattern. Each pixel clock it takes in one 27-bit received word: three 8-bit colour channels plus the horizontal sync, vertical sync and data-enable bits. While the test enable input is low, the incoming words are normal traffic and the checker ignores them.

When the enable goes high, the first word is taken as a seed for a local PRBS-7 generator. Each later word is compared with the next word of that generator. Every word that differs adds one to a saturating error count. The pass flag keeps showing the verdict of the previous test for the whole run. On the first clock after the enable falls, the flag takes the new verdict, which is pass only when no word was wrong. It then holds that verdict while normal traffic resumes.

Top module: `prbs_bist_checker`

## Requirements
- R1: After synchronous reset, `pass_o` is 1 and `err_cnt` is 0.
- R2: The word present on the first edge where `bist_en` is high after being low (or after reset) is the seed. It is not compared, and `err_cnt` reads 0 after that edge.
- R3: The expected word follows the polynomial x^7 + x^6 + 1. The word carries 27 consecutive sequence bits, with bit 26 first and bit 0 last. Each new bit is the XOR of the two oldest bits of the 7-bit history. The history after a word is that word's bits [6:0], and for the seed it is the seed's bits [6:0]. Field layout: red in [26:19], green in [18:11], blue in [10:3], HS in [2], VS in [1], DE in [0].
- R4: Each compared word that differs from the expected word in one or more bits raises `err_cnt` by exactly one, seen after that edge.
- R5: `err_cnt` saturates at 255 and does not wrap.
- R6: While a run is in progress, `pass_o` keeps the verdict of the previous run, or 1 if there has been none.
- R7: On the first edge where `bist_en` is low after a run, `pass_o` becomes 1 if `err_cnt` is 0 and 0 otherwise. `err_cnt` keeps its final value.
- R8: Outside a run, `rx_word` has no effect on `pass_o` or `err_cnt`.
- R9: The expected sequence comes only from local state. A corrupted word does not disturb the checking of the words after it.
- R10: A new run clears the count. A later clean run therefore returns `pass_o` to 1, and this includes a run that holds only the seed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| bist_en | input | 1 | Self-test enable, high for the length of a run |
| rx_word | input | 27 | Received word: RGB 8:8:8 plus HS, VS, DE |
| pass_o | output | 1 | Held verdict, 1 = pass |
| err_cnt | output | 8 | Saturating count of erroneous words in the latest run |

## Verification
The assertions assume that `bist_en` and `rx_word` are synchronous to the pixel clock and stable around each rising edge. They also assume that `bist_en` goes high only with a seed word whose low seven bits match what the sender's generator holds. The bench drives every input on the falling edge and builds each test word from the seed with its own sequence model. It corrupts chosen words by flipping single bits, including back-to-back corrupt words. Every run holds the enable high for a whole number of cycles. Runs of one cycle and of more than 255 bad words cover the edge cases.

// File: rtl/bist_pkg.sv
package bist_pkg;

    localparam int COLOR_W = 8;
    localparam int SYNC_W  = 3;
    localparam int WORD_W  = 3 * COLOR_W + SYNC_W;
    localparam int LFSR_W  = 7;
    localparam int CNT_W   = 8;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    typedef struct packed {
        logic seed;
        logic check;
        logic finish;
    } bist_ctl_t;

    // Next WORD_W bits of x^7 + x^6 + 1 from history st, MSB emitted first.
    function automatic logic [WORD_W-1:0] prbs_next_word(input logic [LFSR_W-1:0] st);
        logic [LFSR_W-1:0] s;
        logic              fb;
        logic [WORD_W-1:0] w;
        s = st;
        w = '0;
        for (int i = WORD_W - 1; i >= 0; i--) begin
            fb   = s[LFSR_W-1] ^ s[LFSR_W-2];
            s    = {s[LFSR_W-2:0], fb};
            w[i] = fb;
        end
        return w;
    endfunction

endpackage

// File: rtl/prbs7_gen.sv
module prbs7_gen
    import bist_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              step,
    input  logic [LFSR_W-1:0] seed,
    output logic [WORD_W-1:0] exp_word
);

    logic [LFSR_W-1:0] hist_q;

    assign exp_word = prbs_next_word(hist_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
        end else if (load) begin
            hist_q <= seed;
        end else if (step) begin
            hist_q <= exp_word[LFSR_W-1:0];
        end
    end

    AST_LOAD_STEP_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(load && step)); // R3

endmodule

// File: rtl/bist_err_counter.sv
module bist_err_counter
    import bist_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);

    localparam logic [W-1:0] CMAX = '1;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (inc && (cnt != CMAX)) begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_CLEAR_ON_SEED: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0)); // R2
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (inc && !clr && cnt != CMAX) |=> (cnt == W'($past(cnt) + 1'b1))); // R4
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (cnt == CMAX && !clr) |=> (cnt == CMAX)); // R5
    AST_COUNT_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!inc && !clr) |=> $stable(cnt)); // R8

endmodule

// File: rtl/bist_verdict.sv
module bist_verdict (
    input  logic clk,
    input  logic rst,
    input  logic latch,
    input  logic clean,
    output logic pass
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pass <= 1'b1;
        end else if (latch) begin
            pass <= clean;
        end
    end

    AST_RESET_PASS: assert property (@(posedge clk)
        rst |=> pass); // R1
    AST_VERDICT_HELD: assert property (@(posedge clk) disable iff (rst)
        !latch |=> $stable(pass)); // R6

endmodule

// File: rtl/prbs_bist_checker.sv
module prbs_bist_checker
    import bist_pkg::*;
#(
    parameter int CNT_BITS = CNT_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bist_en,
    input  logic [WORD_W-1:0]   rx_word,
    output logic                pass_o,
    output logic [CNT_BITS-1:0] err_cnt
);

    phase_e            phase_q;
    bist_ctl_t         ctl;
    logic [WORD_W-1:0] exp_word;
    logic              word_bad;

    always_comb begin
        ctl.seed   = bist_en  && (phase_q == PH_IDLE);
        ctl.check  = bist_en  && (phase_q == PH_RUN);
        ctl.finish = !bist_en && (phase_q == PH_RUN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
        end else if (ctl.seed) begin
            phase_q <= PH_RUN;
        end else if (ctl.finish) begin
            phase_q <= PH_IDLE;
        end
    end

    prbs7_gen u_gen (
        .clk      (clk),
        .rst      (rst),
        .load     (ctl.seed),
        .step     (ctl.check),
        .seed     (rx_word[LFSR_W-1:0]),
        .exp_word (exp_word)
    );

    assign word_bad = ctl.check && (rx_word != exp_word);

    bist_err_counter #(.W(CNT_BITS)) u_cnt (
        .clk (clk),
        .rst (rst),
        .clr (ctl.seed),
        .inc (word_bad),
        .cnt (err_cnt)
    );

    bist_verdict u_verdict (
        .clk   (clk),
        .rst   (rst),
        .latch (ctl.finish),
        .clean (err_cnt == '0),
        .pass  (pass_o)
    );

    AST_RUN_HOLDS_PASS: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_RUN && bist_en) |=> $stable(pass_o)); // R6
    AST_END_VERDICT: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_RUN && !bist_en) |=> (pass_o == ($past(err_cnt) == '0))); // R7
    AST_IDLE_IGNORES: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_IDLE && !bist_en) |=> ($stable(err_cnt) && $stable(pass_o))); // R8

endmodule

// File: tb/prbs_bist_checker_test.sv
module prbs_bist_checker_test;

    localparam int CLK_PERIOD = 10;
    localparam int WW = 27;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bist_en = 1'b0;
    logic [WW-1:0] rx_word = '0;
    logic          pass_o;
    logic [7:0]    err_cnt;

    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;
    logic [6:0] hist;
    int   exp_cnt;

    always #(CLK_PERIOD / 2) clk = ~clk;

    prbs_bist_checker uut (
        .clk     (clk),
        .rst     (rst),
        .bist_en (bist_en),
        .rx_word (rx_word),
        .pass_o  (pass_o),
        .err_cnt (err_cnt)
    );

    // Reference model of R3: 27 sequence bits, first bit lands in bit 26.
    function automatic logic [WW-1:0] model_word(input logic [6:0] st);
        logic [6:0]    r;
        logic [WW-1:0] out;
        logic          b;
        r = st;
        out = '0;
        for (int k = 0; k < WW; k++) begin
            b = r[6] ^ r[5];
            r = {r[5:0], b};
            out[WW-1-k] = b;
        end
        return out;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Drive at a falling edge, return at the next falling edge.
    task automatic cyc(input logic en, input logic [WW-1:0] w);
        bist_en = en;
        rx_word = w;
        @(negedge clk);
    endtask

    task automatic begin_run(input logic [WW-1:0] seed);
        cyc(1'b1, seed);
        hist = seed[6:0];
        exp_cnt = 0;
    endtask

    task automatic send_word(input logic [WW-1:0] flip);
        logic [WW-1:0] w;
        w = model_word(hist);
        cyc(1'b1, w ^ flip);
        hist = w[6:0];
        if (flip != '0 && exp_cnt < 255) exp_cnt++;
    endtask

    task automatic t_reset;
        chk("R1", "pass after reset", 32'(pass_o), 32'd1);
        chk("R1", "count after reset", 32'(err_cnt), 32'd0);
    endtask

    task automatic t_clean_run;
        begin_run(27'h5A5_1234);
        chk("R2", "count after seed", 32'(err_cnt), 32'd0);
        for (int i = 0; i < 12; i++) send_word('0);
        chk("R3", "clean words give no errors", 32'(err_cnt), 32'd0);
        chk("R6", "pass during first run", 32'(pass_o), 32'd1);
        cyc(1'b0, 27'h0);
        chk("R7", "clean verdict", 32'(pass_o), 32'd1);
    endtask

    task automatic t_idle_ignore;
        logic [WW-1:0] pat;
        pat = 27'h7FF_FFFF;
        for (int i = 0; i < 6; i++) begin
            cyc(1'b0, pat);
            pat = {pat[WW-2:0], pat[WW-1] ^ pat[3]};
        end
        chk("R8", "idle traffic keeps pass", 32'(pass_o), 32'd1);
        chk("R8", "idle traffic keeps count", 32'(err_cnt), 32'd0);
    endtask

    task automatic t_error_run;
        begin_run(27'h123_4567);
        for (int i = 1; i <= 10; i++) begin
            logic [WW-1:0] flip;
            flip = '0;
            if (i == 3) flip = 27'h400_0000; // red MSB
            if (i == 4) flip = 27'h000_0001; // DE bit
            if (i == 8) flip = 27'h000_0004; // HS bit
            send_word(flip);
            chk("R4", $sformatf("count after word %0d", i), 32'(err_cnt), 32'(exp_cnt));
        end
        chk("R9", "errors isolated to corrupted words", 32'(err_cnt), 32'd3);
        chk("R6", "pass keeps prior result while errors occur", 32'(pass_o), 32'd1);
        cyc(1'b0, 27'h0);
        chk("R7", "failing verdict", 32'(pass_o), 32'd0);
        chk("R7", "count held after run", 32'(err_cnt), 32'd3);
        cyc(1'b0, 27'h55_5555);
        chk("R8", "fail verdict held in idle", 32'(pass_o), 32'd0);
        chk("R8", "count held in idle", 32'(err_cnt), 32'd3);
    endtask

    task automatic t_rerun_clean;
        begin_run(27'h000_0041);
        chk("R2", "count cleared by new seed", 32'(err_cnt), 32'd0);
        chk("R6", "old fail shown during run", 32'(pass_o), 32'd0);
        for (int i = 0; i < 8; i++) send_word('0);
        chk("R6", "old fail still shown late in run", 32'(pass_o), 32'd0);
        cyc(1'b0, 27'h0);
        chk("R10", "clean rerun restores pass", 32'(pass_o), 32'd1);
        chk("R3", "clean rerun count", 32'(err_cnt), 32'd0);
    endtask

    task automatic t_saturate;
        begin_run(27'h3C3_C3C3);
        for (int i = 0; i < 300; i++) send_word(27'h000_0800);
        chk("R5", "count saturates", 32'(err_cnt), 32'd255);
        cyc(1'b0, 27'h0);
        chk("R7", "saturated run fails", 32'(pass_o), 32'd0);
        chk("R5", "saturated count held", 32'(err_cnt), 32'd255);
    endtask

    task automatic t_seed_only;
        cyc(1'b1, 27'h7FF_FFFF);
        chk("R2", "seed not compared", 32'(err_cnt), 32'd0);
        cyc(1'b0, 27'h0);
        chk("R10", "seed-only run passes", 32'(pass_o), 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_clean_run();
        t_idle_ignore();
        t_error_run();
        t_rerun_clean();
        t_saturate();
        t_seed_only();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule